// File: doc/BRIEF.md
# Power Domain Switch and Bus-Idle Control Registers

This block is a small register unit that controls four power islands. Software writes a target state into a power word. Each island then runs a timed transition before its status bit changes. The unit also holds a bus-idle request word. Each request bit drives a handshake to a stub that stands in for the island's interconnect port. The stub's acknowledge and idle flags are reported back through one combined read-only word.

Each transition has a duration set in the count registers, so driver code can poll the status word to learn when a switch has finished. The islands form two timing groups. Each group has one count for switching off and one for switching on. Islands 0 to 2 share the first group and island 3 uses the second. The analog switches are modelled as down-counters and the interconnect ports as delay lines.

Top module: `pdc_top`

## Requirements
- R1: After reset the power word (0x08), status word (0x0C), request word (0x10) and handshake word (0x14) read zero, all four count words read 24, dom_power_on reads 4'hF and dom_idle_req reads 0.
- R2: The power word holds one bit per island at positions 7, 14, 8, 9 for islands 0 to 3. Writing 1 asks for power-off and writing 0 asks for power-on. All other bits read as zero.
- R3: The status word has island bits at positions 7, 10, 8, 9 for islands 0 to 3, reading 0 when the island is powered and 1 when it is off. After a write edge that changes an island's power bit, its status bit changes exactly N+1 clock edges later, where N is the count in force. A count of 0 gives a one-edge switch.
- R4: Islands 0 to 2 use the count words at 0x34 (off) and 0x38 (on). Island 3 uses 0x3C (off) and 0x40 (on).
- R5: While an island's transition is in progress, writes to its power bit are ignored. Its power bit and its status timing stay as first requested, while other islands accept the same write.
- R6: The request word holds bits 4, 9, 3, 2 for islands 0 to 3, and these drive dom_idle_req.
- R7: In the handshake word, an island's acknowledge flag sits 16 positions above its request bit. It follows the request bit ACK_DLY (default 2) clock edges after the write edge, on both assertion and release.
- R8: In the handshake word, an island's idle flag sits at its request bit position. It follows the acknowledge flag IDLE_DLY (default 1) edges later.
- R9: Writes to 0x0C and 0x14 are ignored. Unmapped addresses read zero. Count words keep only their low CNT_W (default 16) bits.
- R10: dom_power_on bit i is high exactly when island i's status bit reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from bus_addr |
| dom_power_on | output | 4 | Per-island powered indication |
| dom_idle_req | output | 4 | Per-island bus-idle request to the port |

## Verification
The handshake checks assume that software holds each idle request steady for at least ACK_DLY + IDLE_DLY cycles, so that no acknowledge or idle edge appears without the matching level behind it. The stimulus leaves three or more cycles between request changes. The status checks assume that only the transition engine can move a status bit. The stimulus exercises this by issuing power writes back to back, by writing the read-only words, and by using a zero count.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
   localparam int NUM_DOM = 4;
   localparam int NUM_GRP = 2;
   localparam int HS_SHIFT = 16;

   localparam int OFS_PWR  = 'h08;
   localparam int OFS_STAT = 'h0C;
   localparam int OFS_REQ  = 'h10;
   localparam int OFS_HS   = 'h14;

   // island -> bit in power word
   function automatic int pwr_pos(input int d);
      case (d)
         0: return 7;
         1: return 14;
         2: return 8;
         default: return 9;
      endcase
   endfunction

   // island -> bit in status word
   function automatic int stat_pos(input int d);
      case (d)
         0: return 7;
         1: return 10;
         2: return 8;
         default: return 9;
      endcase
   endfunction

   // island -> bit in request word (and idle flag)
   function automatic int req_pos(input int d);
      case (d)
         0: return 4;
         1: return 9;
         2: return 3;
         default: return 2;
      endcase
   endfunction

   // island -> timing group
   function automatic int grp_of(input int d);
      return (d == 3) ? 1 : 0;
   endfunction

   // timing group -> address of its off-count word; on-count is the next word
   function automatic int grp_base(input int g);
      return (g == 0) ? 'h34 : 'h3C;
   endfunction
endpackage

// File: rtl/pdc_switch.sv
module pdc_switch #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             target_off,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             off_q
);
   logic [CNT_W-1:0] remain;
   logic             tgt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         off_q  <= 1'b0;
         tgt_q  <= 1'b0;
         remain <= '0;
      end else if (busy) begin
         if (remain == '0) begin
            off_q <= tgt_q;
            busy  <= 1'b0;
         end else begin
            remain <= remain - 1'b1;
         end
      end else if (start) begin
         busy   <= 1'b1;
         tgt_q  <= target_off;
         remain <= load_val;
      end
   end
endmodule

// File: rtl/pdc_idle_port.sv
module pdc_idle_port #(
   parameter int ACK_DLY  = 2,
   parameter int IDLE_DLY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic ack,
   output logic idle
);
   logic [ACK_DLY-1:0]  ack_line;
   logic [IDLE_DLY-1:0] idle_line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_line  <= '0;
         idle_line <= '0;
      end else begin
         ack_line  <= ACK_DLY'({ack_line, req});
         idle_line <= IDLE_DLY'({idle_line, ack_line[ACK_DLY-1]});
      end
   end

   assign ack  = ack_line[ACK_DLY-1];
   assign idle = idle_line[IDLE_DLY-1];
endmodule

// File: rtl/pdc_top.sv
module pdc_top import pdc_pkg::*; #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 32,
   parameter int CNT_W    = 16,
   parameter int RST_CNT  = 24,
   parameter int ACK_DLY  = 2,
   parameter int IDLE_DLY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_DOM-1:0] dom_power_on,
   output logic [NUM_DOM-1:0] dom_idle_req
);
   localparam int HS_TOP = HS_SHIFT + 15;

   generate
      if (DATA_W < HS_TOP + 1) begin : g_bad_data
         $error("DATA_W too narrow for the handshake word");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("CNT_W out of range");
      end
      if (ACK_DLY < 1 || IDLE_DLY < 1) begin : g_bad_dly
         $error("handshake delays must be at least one cycle");
      end
      if (ADDR_W < 7) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NUM_DOM-1:0] ctl_q;
   logic [NUM_DOM-1:0] stat_q;
   logic [NUM_DOM-1:0] sw_busy;
   logic [NUM_DOM-1:0] req_q;
   logic [NUM_DOM-1:0] ack_w;
   logic [NUM_DOM-1:0] idle_w;

   logic [CNT_W-1:0] cnt_off [NUM_GRP];
   logic [CNT_W-1:0] cnt_on  [NUM_GRP];

   logic wr_pwr, wr_req;
   assign wr_pwr = bus_wr && (bus_addr == ADDR_W'(OFS_PWR));
   assign wr_req = bus_wr && (bus_addr == ADDR_W'(OFS_REQ));

   // transition count words, one off/on pair per group
   generate
      for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
         localparam int BASE = grp_base(g);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_off[g] <= CNT_W'(RST_CNT);
               cnt_on[g]  <= CNT_W'(RST_CNT);
            end else if (bus_wr) begin
               if (bus_addr == ADDR_W'(BASE))
                  cnt_off[g] <= bus_wdata[CNT_W-1:0];
               if (bus_addr == ADDR_W'(BASE + 4))
                  cnt_on[g] <= bus_wdata[CNT_W-1:0];
            end
         end
      end
   endgenerate

   // per-island switch engine and idle port
   generate
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
         localparam int PP = pwr_pos(d);
         localparam int RP = req_pos(d);
         localparam int GP = grp_of(d);

         logic             new_off;
         logic             take;
         logic [CNT_W-1:0] load;

         assign new_off = bus_wdata[PP];
         assign take    = wr_pwr && !sw_busy[d] && (new_off != ctl_q[d]);
         assign load    = new_off ? cnt_off[GP] : cnt_on[GP];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ctl_q[d] <= 1'b0;
               req_q[d] <= 1'b0;
            end else begin
               if (take)
                  ctl_q[d] <= new_off;
               if (wr_req)
                  req_q[d] <= bus_wdata[RP];
            end
         end

         pdc_switch #(.CNT_W(CNT_W)) u_sw (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (take),
            .target_off (new_off),
            .load_val   (load),
            .busy       (sw_busy[d]),
            .off_q      (stat_q[d])
         );

         pdc_idle_port #(.ACK_DLY(ACK_DLY), .IDLE_DLY(IDLE_DLY)) u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_q[d]),
            .ack   (ack_w[d]),
            .idle  (idle_w[d])
         );
      end
   endgenerate

   // word images and read mux
   logic [DATA_W-1:0] img_pwr, img_stat, img_req, img_hs;

   always_comb begin
      img_pwr  = '0;
      img_stat = '0;
      img_req  = '0;
      img_hs   = '0;
      for (int d = 0; d < NUM_DOM; d++) begin
         img_pwr[pwr_pos(d)]             = ctl_q[d];
         img_stat[stat_pos(d)]           = stat_q[d];
         img_req[req_pos(d)]             = req_q[d];
         img_hs[req_pos(d)]              = idle_w[d];
         img_hs[req_pos(d) + HS_SHIFT]   = ack_w[d];
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_PWR):            bus_rdata = img_pwr;
         ADDR_W'(OFS_STAT):           bus_rdata = img_stat;
         ADDR_W'(OFS_REQ):            bus_rdata = img_req;
         ADDR_W'(OFS_HS):             bus_rdata = img_hs;
         ADDR_W'(grp_base(0)):        bus_rdata = DATA_W'(cnt_off[0]);
         ADDR_W'(grp_base(0) + 4):    bus_rdata = DATA_W'(cnt_on[0]);
         ADDR_W'(grp_base(1)):        bus_rdata = DATA_W'(cnt_off[1]);
         ADDR_W'(grp_base(1) + 4):    bus_rdata = DATA_W'(cnt_on[1]);
         default:                     bus_rdata = '0;
      endcase
   end

   assign dom_power_on = ~stat_q;
   assign dom_idle_req = req_q;
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk import pdc_pkg::*; #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [NUM_DOM-1:0] dom_power_on,
   input logic [NUM_DOM-1:0] stat,
   input logic [NUM_DOM-1:0] busy,
   input logic [NUM_DOM-1:0] ctl,
   input logic [NUM_DOM-1:0] req,
   input logic [NUM_DOM-1:0] ack,
   input logic [NUM_DOM-1:0] idle
);
   logic mapped;
   assign mapped = (bus_addr == ADDR_W'(OFS_PWR))  || (bus_addr == ADDR_W'(OFS_STAT)) ||
                   (bus_addr == ADDR_W'(OFS_REQ))  || (bus_addr == ADDR_W'(OFS_HS))   ||
                   (bus_addr == ADDR_W'('h34))     || (bus_addr == ADDR_W'('h38))     ||
                   (bus_addr == ADDR_W'('h3C))     || (bus_addr == ADDR_W'('h40));

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> bus_rdata == '0);

   generate
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_d
         // R3
         stat_only_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !busy[d] |=> $stable(stat[d]));
         // R5
         ctl_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            busy[d] |=> $stable(ctl[d]));
         // R10
         power_on_matches_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bus_addr == ADDR_W'(OFS_STAT) |-> bus_rdata[stat_pos(d)] == !dom_power_on[d]);
         // R7
         ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ack[d]) |-> req[d]);
         // R7
         ack_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ack[d]) |-> !req[d]);
         // R8
         idle_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(idle[d]) |-> ack[d]);
         // R8
         idle_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(idle[d]) |-> !ack[d]);
      end
   endgenerate

   logic unused_ok;
   assign unused_ok = bus_wr;
endmodule

bind pdc_top pdc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_rdata    (bus_rdata),
   .dom_power_on (dom_power_on),
   .stat         (stat_q),
   .busy         (sw_busy),
   .ctl          (ctl_q),
   .req          (req_q),
   .ack          (ack_w),
   .idle         (idle_w)
);

// File: tb/tb_pdc_top.sv
module tb_pdc_top;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  dom_power_on;
   logic [3:0]  dom_idle_req;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pdc_top dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .dom_power_on (dom_power_on),
      .dom_idle_req (dom_idle_req)
   );

   // kind: 0 write, 1 read and compare, 2 idle cycles (count in data)
   typedef struct packed {
      logic [1:0]  kind;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [3:0]  tag;
   } vec_t;

   localparam int NV = 50;
   localparam vec_t TBL [NV] = '{
      '{2'd0, 8'h34, 32'd3,          4'd4},  // R4 group0 off count
      '{2'd0, 8'h38, 32'd5,          4'd4},
      '{2'd0, 8'h3C, 32'd2,          4'd4},
      '{2'd0, 8'h40, 32'd4,          4'd4},
      '{2'd1, 8'h34, 32'd3,          4'd4},  // R4
      '{2'd1, 8'h40, 32'd4,          4'd4},
      '{2'd0, 8'h08, 32'h80,         4'd3},  // island0 off
      '{2'd1, 8'h08, 32'h80,         4'd2},  // R2
      '{2'd1, 8'h0C, 32'h0,          4'd3},  // R3 not yet
      '{2'd2, 8'h00, 32'd3,          4'd3},
      '{2'd1, 8'h0C, 32'h0,          4'd3},  // R3 one edge early
      '{2'd2, 8'h00, 32'd1,          4'd3},
      '{2'd1, 8'h0C, 32'h80,         4'd3},  // R3 at N+1
      '{2'd0, 8'h08, 32'h200,        4'd4},  // island0 on, island3 off
      '{2'd2, 8'h00, 32'd3,          4'd4},
      '{2'd1, 8'h0C, 32'h280,        4'd4},  // R4 group1 done first
      '{2'd2, 8'h00, 32'd3,          4'd4},
      '{2'd1, 8'h0C, 32'h200,        4'd4},
      '{2'd0, 8'h08, 32'h4000,       4'd5},  // R5 island1 off, island3 on
      '{2'd0, 8'h08, 32'h0,          4'd5},  // ignored while busy
      '{2'd1, 8'h08, 32'h4000,       4'd5},
      '{2'd2, 8'h00, 32'd3,          4'd5},
      '{2'd1, 8'h0C, 32'h600,        4'd5},
      '{2'd2, 8'h00, 32'd1,          4'd5},
      '{2'd1, 8'h0C, 32'h400,        4'd5},
      '{2'd0, 8'h10, 32'h10,         4'd6},  // R6 island0 idle request
      '{2'd1, 8'h10, 32'h10,         4'd6},
      '{2'd1, 8'h14, 32'h0,          4'd7},  // R7
      '{2'd2, 8'h00, 32'd2,          4'd7},
      '{2'd1, 8'h14, 32'h0010_0000,  4'd7},
      '{2'd2, 8'h00, 32'd1,          4'd8},
      '{2'd1, 8'h14, 32'h0010_0010,  4'd8},  // R8
      '{2'd0, 8'h10, 32'h0,          4'd7},
      '{2'd2, 8'h00, 32'd2,          4'd7},
      '{2'd1, 8'h14, 32'h10,         4'd7},  // R7 release
      '{2'd2, 8'h00, 32'd1,          4'd8},
      '{2'd1, 8'h14, 32'h0,          4'd8},  // R8 release
      '{2'd0, 8'h0C, 32'hFFFF_FFFF,  4'd9},  // R9 read-only
      '{2'd1, 8'h0C, 32'h400,        4'd9},
      '{2'd0, 8'h14, 32'hFFFF_FFFF,  4'd9},
      '{2'd1, 8'h14, 32'h0,          4'd9},
      '{2'd1, 8'h20, 32'h0,          4'd9},
      '{2'd1, 8'h44, 32'h0,          4'd9},
      '{2'd1, 8'h00, 32'h0,          4'd9},
      '{2'd0, 8'h08, 32'hFFFF_FFFF,  4'd2},  // R2 only island bits stick
      '{2'd1, 8'h08, 32'h4380,       4'd2},
      '{2'd0, 8'h10, 32'hFFFF_FFFF,  4'd6},
      '{2'd1, 8'h10, 32'h21C,        4'd6},  // R6
      '{2'd2, 8'h00, 32'd3,          4'd7},
      '{2'd1, 8'h14, 32'h021C_021C,  4'd7}   // R7 R8 all islands
   };

   task automatic check(input int tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL R%0d actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
      bus_wr    = 1'b1;
      bus_addr  = a;
      bus_wdata = v;
      @(posedge clk);
      @(negedge clk);
      bus_wr    = 1'b0;
   endtask

   task automatic bus_check(input int tag, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      bus_check(1, 8'h08, 32'h0);
      bus_check(1, 8'h0C, 32'h0);
      bus_check(1, 8'h10, 32'h0);
      bus_check(1, 8'h14, 32'h0);
      bus_check(1, 8'h34, 32'd24);
      bus_check(1, 8'h38, 32'd24);
      bus_check(1, 8'h3C, 32'd24);
      bus_check(1, 8'h40, 32'd24);
      check(1, {28'h0, dom_power_on}, 32'hF);
      check(1, {28'h0, dom_idle_req}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         case (TBL[i].kind)
            2'd0: bus_write(TBL[i].addr, TBL[i].data);
            2'd1: bus_check(int'(TBL[i].tag), TBL[i].addr, TBL[i].data);
            default: repeat (int'(TBL[i].data)) @(negedge clk);
         endcase
      end

      // R10 all islands off after the all-ones power write settles
      repeat (2) @(negedge clk);
      bus_check(3, 8'h0C, 32'h780);
      check(10, {28'h0, dom_power_on}, 32'h0);
      check(6, {28'h0, dom_idle_req}, 32'hF);

      // R3 zero count: switch completes one edge after the write
      bus_write(8'h38, 32'd0);
      bus_write(8'h08, 32'h200);
      bus_check(3, 8'h0C, 32'h780);
      @(negedge clk);
      bus_check(3, 8'h0C, 32'h200);
      check(10, {28'h0, dom_power_on}, 32'h7);

      // R9 count width
      bus_write(8'h34, 32'hFFFF_FFFF);
      bus_check(9, 8'h34, 32'h0000_FFFF);

      finish_run();
   end
endmodule